// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block divides an input clock by a programmable ratio that can be set in half-period steps. Each cycle of the design clock stands for one half period of the input signal, so one design cycle matches one input edge, rising and falling in turn. The ratio is a 10-bit word counted in half periods, which is twice the modulus. Bit 0 is the half step. The first divider stage stretches its output by one half period when asked, so no quadrature phase selection is needed. Behind it sits a chain of eight divide-by-2-or-3 stages. Each of them adds one of its own input periods once per output cycle when its word bit is set.

A 2-bit length code sets how many of the eight chain stages are in use. That sets the legal ratio window and takes the range down to a modulus of 32. A load strobe captures a new word and code, checked against the window. The new setting only takes effect when the current output cycle ends. The output is a one-tick pulse that marks the end of each divided cycle.

Top module: `hs_frac_divider`

## Requirements
- R1: While reset is high, `div_out` is low. After reset the setting is word 64 with length code 0. The first `div_out` pulse comes 64 ticks after the first clock edge with reset low.
- R2: The distance between consecutive `div_out` rising edges, counted in design clock ticks (half input periods), equals the word in effect. Odd counts, meaning half-integer moduli, are produced exactly.
- R3: Length code e (0..3) enables 5+e chain stages. The legal word window is then 2^(e+6) to 2^(e+7)-1, which is modulus 32..63.5 for code 0 up to 256..511.5 for code 3.
- R4: A loaded word below the window for its length code, including zero, is replaced by the window minimum. A word above the window is replaced by the window maximum.
- R5: A new setting loaded during an output cycle leaves that cycle at its old length. It governs the output from the following cycle on.
- R6: Changes on `mod_word` or `ext_code` while `mod_load` is low have no effect on the output period.
- R7: Every `div_out` pulse is exactly one tick wide.
- R8: When several strobes arrive within one output cycle, the last one decides the next cycle's ratio.
- R9: With a fixed odd word, every output cycle has the same odd length, so the half-period stretch happens once per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock, one tick per half input period |
| rst | input | 1 | Synchronous active-high reset |
| mod_word | input | 10 | Ratio in half periods (bit 0 = half step) |
| ext_code | input | 2 | Chain length code, 5+code stages active |
| mod_load | input | 1 | Strobe that captures `mod_word` and `ext_code` |
| div_out | output | 1 | One-tick pulse at the end of each divided cycle |

## Verification
The bench sweeps every legal word for the two shortest chain lengths, plus chosen points at the longer ones. A stage that swallowed at the wrong weight, or twice per cycle, would show up there as a period error. Odd words are the key corner: a first stage that stretched by a full period instead of half would add one tick. Words just outside each window and the all-zero word test the clamp, where a missing clamp would give a chain that ran short or long. Loading in mid-cycle, loading twice, and changing inputs without a strobe each test the point where a new ratio takes effect. A design that applied the word at once would cut the running cycle short.

// File: rtl/hsdiv_pkg.sv
`timescale 1ns/1ps
package hsdiv_pkg;
  localparam int NCELL   = 8;                           // divide-by-2/3 stages
  localparam int EXT_W   = 2;                           // length code width
  localparam int WORD_W  = NCELL + 2;                   // ratio word in half periods
  localparam int MIN_LEN = NCELL - (2**EXT_W) + 1;      // shortest active chain
  localparam int SEL_W   = $clog2(NCELL + 1);

  function automatic logic [WORD_W:0] win_lo(input logic [EXT_W-1:0] e);
    return (WORD_W+1)'(1) << (MIN_LEN + int'(e) + 1);
  endfunction

  function automatic logic [WORD_W:0] win_hi(input logic [EXT_W-1:0] e);
    return ((WORD_W+1)'(1) << (MIN_LEN + int'(e) + 2)) - (WORD_W+1)'(1);
  endfunction

  function automatic logic [WORD_W-1:0] fit_word(input logic [WORD_W-1:0] w,
                                                 input logic [EXT_W-1:0] e);
    logic [WORD_W:0] lo, hi;
    lo = win_lo(e);
    hi = win_hi(e);
    if ({1'b0, w} < lo) return lo[WORD_W-1:0];
    if ({1'b0, w} > hi) return hi[WORD_W-1:0];
    return w;
  endfunction
endpackage

// File: rtl/hs_edge_cell.sv
`timescale 1ns/1ps
// First stage: passes two ticks (one full input period) per output cycle,
// or three ticks when asked to stretch by half a period.
module hs_edge_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sw_bit,
  input  logic restart,
  output logic emit
);
  logic ph;     // 0: rising-edge tick, 1: falling-edge tick
  logic held;   // half period already swallowed this cycle
  logic due;    // stretch still owed in this output cycle

  assign emit = en && ph && !(sw_bit && due && !held);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= 1'b0;
      held <= 1'b0;
      due  <= 1'b1;
    end else begin
      if (en) begin
        if (!ph) ph <= 1'b1;
        else if (emit) begin
          ph   <= 1'b0;
          held <= 1'b0;
        end else held <= 1'b1;
      end
      if (restart)   due <= 1'b1;
      else if (emit) due <= 1'b0;
    end
  end

  // R9: the stretch lasts one tick and only follows a falling-edge tick
  held_phase_chk: assert property (@(posedge clk) disable iff (rst)
    held |-> ph);
  // R9
  held_once_chk: assert property (@(posedge clk) disable iff (rst)
    (held && en) |-> emit);
endmodule

// File: rtl/hs_swallow_cell.sv
`timescale 1ns/1ps
// Divide-by-2/3 stage: two input pulses per output, three once per cycle
// when its word bit is set.
module hs_swallow_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sw_bit,
  input  logic restart,
  output logic emit
);
  logic [1:0] cnt;
  logic       due;
  logic [1:0] term;

  assign term = (sw_bit && due) ? 2'd2 : 2'd1;
  assign emit = en && (cnt == term);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= 2'd0;
      due <= 1'b1;
    end else begin
      if (en) cnt <= emit ? 2'd0 : cnt + 2'd1;
      if (restart)   due <= 1'b1;
      else if (emit) due <= 1'b0;
    end
  end

  // R2: a stage never runs past three input pulses
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt != 2'd3);
  // R2: after the chain restarts, every stage begins a fresh cycle
  restart_clean_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == 2'd0));
endmodule

// File: rtl/hs_mod_cfg.sv
`timescale 1ns/1ps
module hs_mod_cfg
  import hsdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mod_word,
  input  logic [EXT_W-1:0]  ext_code,
  input  logic              mod_load,
  input  logic              cycle_end,
  output logic [WORD_W-1:0] cur_word,
  output logic [EXT_W-1:0]  cur_ext
);
  logic              pend_vld;
  logic [WORD_W-1:0] pend_word;
  logic [EXT_W-1:0]  pend_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_word <= '0;
      pend_ext  <= '0;
      cur_word  <= win_lo('0)[WORD_W-1:0];
      cur_ext   <= '0;
    end else begin
      if (mod_load) begin
        pend_word <= fit_word(mod_word, ext_code);
        pend_ext  <= ext_code;
      end
      if (cycle_end && pend_vld) begin
        cur_word <= pend_word;
        cur_ext  <= pend_ext;
      end
      if (mod_load)       pend_vld <= 1'b1;
      else if (cycle_end) pend_vld <= 1'b0;
    end
  end

  // R4
  word_window_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cur_word} >= win_lo(cur_ext)) && ({1'b0, cur_word} <= win_hi(cur_ext)));
  // R5
  hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> ($stable(cur_word) && $stable(cur_ext)));
endmodule

// File: rtl/hs_frac_divider.sv
`timescale 1ns/1ps
module hs_frac_divider
  import hsdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mod_word,
  input  logic [EXT_W-1:0]  ext_code,
  input  logic              mod_load,
  output logic              div_out
);
  logic [WORD_W-1:0] cur_word;
  logic [EXT_W-1:0]  cur_ext;
  logic [NCELL:0]    emit;
  logic [NCELL:0]    en;
  logic [SEL_W-1:0]  last_idx;
  logic              top_done;

  assign last_idx = SEL_W'(MIN_LEN) + SEL_W'(cur_ext);
  assign top_done = emit[last_idx];

  hs_mod_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .mod_word  (mod_word),
    .ext_code  (ext_code),
    .mod_load  (mod_load),
    .cycle_end (top_done),
    .cur_word  (cur_word),
    .cur_ext   (cur_ext)
  );

  genvar i;
  generate
    for (i = 0; i <= NCELL; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign en[i] = 1'b1;
        hs_edge_cell u_cell (
          .clk (clk), .rst (rst), .en (en[i]), .sw_bit (cur_word[i]),
          .restart (top_done), .emit (emit[i])
        );
      end else begin : g_chain
        assign en[i] = emit[i-1] && (SEL_W'(i) <= last_idx);
        hs_swallow_cell u_cell (
          .clk (clk), .rst (rst), .en (en[i]), .sw_bit (cur_word[i]),
          .restart (top_done), .emit (emit[i])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= top_done;
  end

  // Checker state: ticks since the last cycle end
  logic [WORD_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || top_done) gap_q <= '0;
    else                 gap_q <= gap_q + 1'b1;
  end

  // R2
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    top_done |-> (WORD_W'(gap_q + 1'b1) == cur_word));
  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !div_out);
endmodule

// File: tb/tb_hs_frac_divider.sv
`timescale 1ns/1ps
module tb_hs_frac_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] mod_word = '0;
  logic [1:0] ext_code = '0;
  logic       mod_load = 1'b0;
  logic       div_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hs_frac_divider dut (
    .clk (clk), .rst (rst), .mod_word (mod_word),
    .ext_code (ext_code), .mod_load (mod_load), .div_out (div_out)
  );

  // {word, code, expected period in ticks}
  localparam logic [21:0] VEC [15] = '{
    {10'd64,   2'd0, 10'd64},   {10'd127,  2'd0, 10'd127},
    {10'd65,   2'd0, 10'd65},   {10'd0,    2'd0, 10'd64},
    {10'd200,  2'd0, 10'd127},  {10'd128,  2'd1, 10'd128},
    {10'd255,  2'd1, 10'd255},  {10'd100,  2'd1, 10'd128},
    {10'd777,  2'd2, 10'd511},  {10'd301,  2'd2, 10'd301},
    {10'd1023, 2'd3, 10'd1023}, {10'd513,  2'd3, 10'd513},
    {10'd5,    2'd3, 10'd512},  {10'd0,    2'd3, 10'd512},
    {10'd700,  2'd1, 10'd255}
  };

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Counts sampling points until div_out is seen high
  task automatic wait_rise(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      mod_load = 1'b0;
      n++;
      if (div_out) break;
      if (n > 3000) begin
        check("watchdog R2 no pulse", n, 0);
        break;
      end
    end
  endtask

  // Called right after a rise: load, finish old cycle, measure new one
  task automatic program_measure(input logic [9:0] w, input logic [1:0] e,
                                 output int old_n, output int new_n);
    mod_word = w;
    ext_code = e;
    mod_load = 1'b1;
    wait_rise(old_n);
    wait_rise(new_n);
  endtask

  initial begin
    int n, m;
    // R1: output quiet in reset
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R1 reset div_out", int'(div_out), 0);
    end
    rst = 1'b0;
    wait_rise(n);
    check("R1 first pulse after reset", n, 64);
    @(negedge clk);
    check("R7 pulse one tick wide", int'(div_out), 0);
    wait_rise(n);
    check("R2 default period", n + 1, 64);

    // Table walk: R2 periods, R3 windows, R4 clamp
    for (int i = 0; i < 15; i++) begin
      program_measure(VEC[i][21:12], VEC[i][11:10], n, m);
      check("R2 R3 R4 table period", m, int'(VEC[i][9:0]));
    end

    // R9: odd word repeats the same odd length
    program_measure(10'd101, 2'd0, n, m);
    check("R9 odd period first", m, 101);
    wait_rise(n);
    check("R9 odd period repeat", n, 101);

    // R5: mid-cycle load keeps the running cycle
    program_measure(10'd300, 2'd2, n, m);
    check("R5 running cycle keeps old ratio", n, 101);
    check("R5 new ratio next cycle", m, 300);

    // R6: input changes without strobe are ignored
    mod_word = 10'd100;
    ext_code = 2'd0;
    wait_rise(n);
    check("R6 no strobe no change", n, 300);
    wait_rise(n);
    check("R6 no strobe second cycle", n, 300);

    // R8: last strobe in a cycle wins
    mod_word = 10'd70; ext_code = 2'd0; mod_load = 1'b1;
    @(negedge clk);
    mod_word = 10'd90; mod_load = 1'b1;
    wait_rise(n);
    check("R8 old cycle finishes", n + 1, 300);
    wait_rise(n);
    check("R8 last strobe wins", n, 90);
    @(negedge clk);
    check("R7 pulse low after rise", int'(div_out), 0);
    wait_rise(n);
    check("R8 steady", n + 1, 90);

    // Sweep every legal word for codes 0 and 1 (R2, R3)
    for (int w = 64; w < 256; w++) begin
      program_measure(10'(w), (w < 128) ? 2'd0 : 2'd1, n, m);
      check("R2 R3 sweep period", m, w);
    end

    // R1: reset mid-run returns to default
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset again div_out", int'(div_out), 0);
    rst = 1'b0;
    wait_rise(n);
    check("R1 default after second reset", n, 64);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      check("watchdog R2 timeout", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule